// File: doc/BRIEF.md
# Clock Trim Successive-Approximation Controller

This block calibrates an on-chip oscillator without software help. A test fixture supplies a precise reference pulse. The controller tunes an 8-bit trim code by binary search until the oscillator's bus clock matches that reference. In each step it measures how long the reference stays high, counted in units of four bus clocks. It compares that count with a fixed expected value and moves the trim code toward the target. The step size halves on every pass. In this trim scheme a lower code gives a faster oscillator. A clock that runs slow therefore pulls the code down, and a clock that runs fast pushes it up.

A sequence is launched by a start pulse. It always runs exactly eight measurement passes. At the end it raises a done flag and emits a single-cycle write strobe together with the final code, so that surrounding logic can save the code to non-volatile storage. The reference input is asynchronous to the bus clock and is synchronized inside the block.

Top module: `clk_trim_sar`

## Requirements
- R1: After reset, trim_o is 0x80, done_o is 0 and store_we_o is 0.
- R2: A start_i pulse accepted while idle sets trim_o to 0x80, clears done_o and begins pass 1. The new trim_o value is visible one clock after the start edge.
- R3: A pass measures the high phase of ref_i. It begins at the first rising edge seen after the pass starts and ends at the next falling edge. The count is floor(H/PRESCALE) for a high phase of H bus clocks, with PRESCALE = 4 by default. A pulse that is already high when the sequence starts is not measured.
- R4: If the count is below EXPECTED, pass n (1..8) lowers trim_o by 128>>n. The step is therefore 64, 32, 16, 8, 4, 2, 1 and finally 0.
- R5: If the count is above EXPECTED, pass n raises trim_o by 128>>n.
- R6: If the count equals EXPECTED, trim_o is left unchanged for that pass.
- R7: A sequence consists of exactly eight passes. done_o stays 0 after passes 1 to 7 and is 1 after pass 8.
- R8: On completion, store_we_o pulses for exactly one cycle, in the same cycle that done_o rises. store_data_o equals the final trim_o while the strobe is high. Each sequence produces exactly one strobe.
- R9: A start_i pulse that arrives while a sequence is running has no effect. The running sequence keeps its code and pass count.
- R10: Adjustments saturate at 0x00 and 0xFF and never wrap. A full sequence from 0x80 always ends within 0x01..0xFF.
- R11: Once done_o is set, trim_o holds the final code until the next accepted start_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock of the oscillator being trimmed |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launches a trim sequence when idle |
| ref_i | input | 1 | Asynchronous precision reference pulse |
| trim_o | output | 8 | Trim code driving the oscillator |
| done_o | output | 1 | Set when a sequence completes, cleared by the next start |
| store_we_o | output | 1 | One-cycle strobe to save the final code |
| store_data_o | output | 8 | Code to be saved, valid with store_we_o |

## Verification
The assertions assume that start_i is a level sampled on the bus clock. They also assume that ref_i stays low long enough between pulses for the two-flop synchronizer to show the falling edge before the next rising edge. The stimulus keeps every reference phase at least twelve clocks long and changes inputs only on the falling clock edge. The bench shrinks the expected count to 20 so that the high phases stay near 80 clocks. It draws random pulse widths within a few prescale units of the target, so that passes too slow, too fast and matching all occur in mixed orders.

// File: rtl/clk_trim_pkg.sv
// Shared types for the clock trim controller.
// Assumes: used by every module of the clk_trim_sar hierarchy.
package clk_trim_pkg;

    // Sequencer state: idle, or waiting for/measuring a reference pulse
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_MEASURE = 1'b1
    } trim_state_e;

    // Outcome of comparing the measured count with the expected count
    typedef enum logic [1:0] {
        CMP_SLOW  = 2'd0,
        CMP_MATCH = 2'd1,
        CMP_FAST  = 2'd2
    } trim_cmp_e;

endpackage

// File: rtl/ref_edge_sync.sv
// Synchronizes the asynchronous reference input and flags its edges.
// Assumes: ref_i may change at any time; the level is then held for several
// clocks, so a rising and a falling edge never fall in the same cycle.
module ref_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Capture chain: the first flop samples the pin, later flops settle it
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= ref_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the settled level, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    // Edge decode from the settled level and its delayed copy
    always_comb begin
        level_o = chain_q[STAGES-1];
        rise_o  = level_o & ~prev_q;
        fall_o  = ~level_o & prev_q;
    end

endmodule

// File: rtl/width_meter.sv
// Counts the high phase of the synchronized reference in prescaled units.
// Assumes: arm_i is held for the whole pass. Only a rising edge seen while
// armed opens a measurement. valid_o pulses on the closing falling edge, and
// count_o is then floor(high cycles / PRESCALE), saturating at full scale.
module width_meter #(
    parameter int PRESCALE = 4,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             level_i,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] count_o
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic             open_q;
    logic [PRE_W-1:0] pre_q, pre_d, pre_base;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
    logic             tick;

    // Next prescaler and count; a rising edge restarts both from zero
    always_comb begin
        tick     = arm_i & (rise_i | (open_q & level_i));
        pre_base = rise_i ? '0 : pre_q;
        cnt_base = rise_i ? '0 : cnt_q;
        pre_d    = pre_q;
        cnt_d    = cnt_q;
        if (tick) begin
            if (pre_base == PRE_LAST) begin
                pre_d = '0;
                cnt_d = (&cnt_base) ? cnt_base : cnt_base + CNT_W'(1);
            end else begin
                pre_d = pre_base + PRE_W'(1);
                cnt_d = cnt_base;
            end
        end
    end

    // Measurement window and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            pre_q  <= '0;
            cnt_q  <= '0;
        end else begin
            pre_q <= pre_d;
            cnt_q <= cnt_d;
            if (!arm_i || fall_i) open_q <= 1'b0;
            else if (rise_i)      open_q <= 1'b1;
        end
    end

    // Result is complete when the open window sees the falling edge
    always_comb begin
        valid_o = arm_i & open_q & fall_i;
        count_o = cnt_q;
    end

endmodule

// File: rtl/trim_stepper.sv
// Computes the next trim code for one pass of the binary search.
// Assumes: iter_i counts passes from 1. The step is the mid-scale code
// shifted right by iter_i. Slow lowers the code, fast raises it, both saturating.
module trim_stepper
    import clk_trim_pkg::*;
#(
    parameter int TRIM_W = 8,
    parameter int ITER_W = 4
) (
    input  logic [TRIM_W-1:0] code_i,
    input  logic [ITER_W-1:0] iter_i,
    input  trim_cmp_e         cmp_i,
    output logic [TRIM_W-1:0] code_o
);

    localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

    logic [TRIM_W-1:0] step;
    logic [TRIM_W:0]   up_sum;

    // Halving step and saturating add or subtract
    always_comb begin
        step   = MID >> iter_i;
        up_sum = {1'b0, code_i} + {1'b0, step};
        case (cmp_i)
            CMP_SLOW: code_o = (code_i < step) ? '0 : code_i - step;
            CMP_FAST: code_o = up_sum[TRIM_W] ? '1 : up_sum[TRIM_W-1:0];
            default:  code_o = code_i;
        endcase
    end

endmodule

// File: rtl/clk_trim_sar.sv
// Top of the clock trim controller: sequences eight measure-and-adjust passes.
// Assumes: start_i is synchronous to clk. ref_i is asynchronous, with phases
// several clocks long. The expected count corresponds to the target bus clock.
module clk_trim_sar
    import clk_trim_pkg::*;
#(
    parameter int TRIM_W   = 8,
    parameter int PRESCALE = 4,
    parameter int EXPECTED = 500,
    parameter int ITERS    = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ref_i,
    output logic [TRIM_W-1:0] trim_o,
    output logic              done_o,
    output logic              store_we_o,
    output logic [TRIM_W-1:0] store_data_o
);

    localparam int CNT_W = $clog2(EXPECTED + 1) + 2;
    localparam int ITER_W = $clog2(ITERS + 1);
    localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);
    localparam logic [CNT_W-1:0] EXP_CNT = CNT_W'(EXPECTED);
    localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(ITERS);

    trim_state_e       state_q;
    logic [TRIM_W-1:0] trim_q, trim_next;
    logic [ITER_W-1:0] iter_q;
    logic              done_q, we_q;
    logic [TRIM_W-1:0] data_q;
    logic              ref_level, ref_rise, ref_fall;
    logic              meas_valid;
    logic [CNT_W-1:0]  meas_count;
    trim_cmp_e         cmp;

    ref_edge_sync #(
        .STAGES (SYNC_STG)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_i   (ref_i),
        .level_o (ref_level),
        .rise_o  (ref_rise),
        .fall_o  (ref_fall)
    );

    width_meter #(
        .PRESCALE (PRESCALE),
        .CNT_W    (CNT_W)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (state_q == ST_MEASURE),
        .level_i (ref_level),
        .rise_i  (ref_rise),
        .fall_i  (ref_fall),
        .valid_o (meas_valid),
        .count_o (meas_count)
    );

    // Classify the finished measurement against the expected count
    always_comb begin
        if (meas_count < EXP_CNT)      cmp = CMP_SLOW;
        else if (meas_count > EXP_CNT) cmp = CMP_FAST;
        else                           cmp = CMP_MATCH;
    end

    trim_stepper #(
        .TRIM_W (TRIM_W),
        .ITER_W (ITER_W)
    ) u_step (
        .code_i (trim_q),
        .iter_i (iter_q),
        .cmp_i  (cmp),
        .code_o (trim_next)
    );

    // Sequencer: launch, apply each pass, finish with the store strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            trim_q  <= MID;
            iter_q  <= ITER_W'(1);
            done_q  <= 1'b0;
            we_q    <= 1'b0;
            data_q  <= '0;
        end else begin
            we_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        trim_q  <= MID;
                        iter_q  <= ITER_W'(1);
                        done_q  <= 1'b0;
                        state_q <= ST_MEASURE;
                    end
                end
                default: begin
                    if (meas_valid) begin
                        trim_q <= trim_next;
                        if (iter_q == LAST_ITER) begin
                            done_q  <= 1'b1;
                            we_q    <= 1'b1;
                            data_q  <= trim_next;
                            state_q <= ST_IDLE;
                        end else begin
                            iter_q <= iter_q + ITER_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    // Output drive from the sequencer registers
    always_comb begin
        trim_o       = trim_q;
        done_o       = done_q;
        store_we_o   = we_q;
        store_data_o = data_q;
    end

endmodule

// File: rtl/clk_trim_sar_chk.sv
// Property checker for clk_trim_sar, attached by bind.
// Assumes: sees the top's ports and its pass counter.
module clk_trim_sar_chk #(
    parameter int TRIM_W = 8,
    parameter int ITER_W = 4,
    parameter int ITERS  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [TRIM_W-1:0] trim_o,
    input logic              done_o,
    input logic              store_we_o,
    input logic [TRIM_W-1:0] store_data_o,
    input logic [ITER_W-1:0] iter
);

    localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

    assert_store_matches_trim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_we_o |-> (store_data_o == trim_o));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        store_we_o |=> !store_we_o);

    assert_done_rise_with_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> store_we_o);

    assert_hold_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(trim_o));

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (trim_o == MID && !done_o));

    assert_iter_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iter >= ITER_W'(1)) && (iter <= ITER_W'(ITERS)));

endmodule

bind clk_trim_sar clk_trim_sar_chk #(
    .TRIM_W (TRIM_W),
    .ITER_W (ITER_W),
    .ITERS  (ITERS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .trim_o       (trim_o),
    .done_o       (done_o),
    .store_we_o   (store_we_o),
    .store_data_o (store_data_o),
    .iter         (iter_q)
);

// File: tb/clk_trim_sar_tb.sv
// Self-checking bench for clk_trim_sar: directed corners plus seeded random widths.
module clk_trim_sar_tb;

    localparam int EXP  = 20;
    localparam int PRE  = 4;
    localparam int GAP  = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       ref_i = 1'b0;
    logic [7:0] trim_o;
    logic       done_o;
    logic       store_we_o;
    logic [7:0] store_data_o;

    int checks = 0;
    int errors = 0;
    int st_cnt = 0;
    logic [7:0] st_data = 8'h00;
    logic       st_done = 1'b0;

    always #2.5 clk = ~clk;

    clk_trim_sar #(
        .PRESCALE (PRE),
        .EXPECTED (EXP)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .ref_i        (ref_i),
        .trim_o       (trim_o),
        .done_o       (done_o),
        .store_we_o   (store_we_o),
        .store_data_o (store_data_o)
    );

    // Record store strobes as seen at the ports
    always @(negedge clk) begin
        if (store_we_o) begin
            st_cnt  <= st_cnt + 1;
            st_data <= store_data_o;
            st_done <= done_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model of one pass
    function automatic int model_step(input int code, input int n, input int h);
        int c, s;
        c = h / PRE;
        s = 128 >> n;
        if (c < EXP) return (code < s) ? 0 : code - s;
        if (c > EXP) return (code + s > 255) ? 255 : code + s;
        return code;
    endfunction

    function automatic string req_of(input int h);
        if (h / PRE < EXP) return "R4";
        if (h / PRE > EXP) return "R5";
        return "R6";
    endfunction

    task automatic pulse(input int h);
        ref_i = 1'b1;
        tick(h);
        ref_i = 1'b0;
        tick(GAP);
    endtask

    task automatic start_pulse();
        start_i = 1'b1;
        tick(1);
        start_i = 1'b0;
    endtask

    // One full sequence; optional pre-high reference and mid-run restart attempt
    task automatic run_seq(input int hw[8], input bit pre_high, input bit poke);
        int model, st_before;
        model = 128;
        st_before = st_cnt;
        if (pre_high) begin
            ref_i = 1'b1;
            tick(5);
        end
        start_pulse();
        check(trim_o == 8'h80, "R2 trim after start", trim_o, 8'h80);
        check(done_o == 1'b0, "R2 done cleared", done_o, 0);
        if (pre_high) begin
            tick(30);
            ref_i = 1'b0;
            tick(GAP);
            check(trim_o == 8'h80, "R3 pre-high pulse ignored", trim_o, 8'h80);
        end else begin
            tick(GAP);
        end
        for (int i = 0; i < 8; i++) begin
            pulse(hw[i]);
            model = model_step(model, i + 1, hw[i]);
            check(trim_o == model[7:0], req_of(hw[i]), trim_o, model);
            check(trim_o != 8'h00, "R10 no wrap to zero", trim_o, model);
            if (i < 7) check(done_o == 1'b0, "R7 not done early", done_o, 0);
            if (poke && i == 3) begin
                start_pulse();
                tick(2);
                check(trim_o == model[7:0], "R9 start ignored when busy", trim_o, model);
            end
        end
        check(done_o == 1'b1, "R7 done after eight passes", done_o, 1);
        check(st_cnt == st_before + 1, "R8 one strobe", st_cnt - st_before, 1);
        check(st_data == model[7:0], "R8 stored code", st_data, model);
        check(st_done == 1'b1, "R8 done with strobe", st_done, 1);
        tick(40);
        check(trim_o == model[7:0], "R11 code held", trim_o, model);
        check(st_cnt == st_before + 1, "R8 no extra strobe", st_cnt - st_before, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hw[8];
        void'($urandom(32'd4711));
        tick(4);
        check(trim_o == 8'h80, "R1 reset trim", trim_o, 8'h80);
        check(done_o == 1'b0, "R1 reset done", done_o, 0);
        check(store_we_o == 1'b0, "R1 reset strobe", store_we_o, 0);
        rst_n = 1'b1;
        tick(3);

        // Always slow, one below the count boundary (R3 floor, R4, R10)
        for (int i = 0; i < 8; i++) hw[i] = PRE * EXP - 1;
        run_seq(hw, 1'b0, 1'b0);
        check(trim_o == 8'h01, "R10 low end", trim_o, 8'h01);

        // Always fast (R5, R10)
        for (int i = 0; i < 8; i++) hw[i] = PRE * (EXP + 1);
        run_seq(hw, 1'b0, 1'b0);
        check(trim_o == 8'hFF, "R10 high end", trim_o, 8'hFF);

        // Exact match at both ends of the bucket (R3, R6)
        for (int i = 0; i < 8; i++) hw[i] = (i % 2 == 0) ? PRE * EXP : PRE * EXP + PRE - 1;
        run_seq(hw, 1'b0, 1'b0);

        // Reference already high at start, and start while busy (R3, R9)
        for (int i = 0; i < 8; i++) hw[i] = (i % 3 == 0) ? PRE * EXP - 6 : PRE * EXP + 7;
        run_seq(hw, 1'b1, 1'b1);

        // Seeded random widths around the target
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < 8; i++) hw[i] = PRE * EXP - 12 + int'($urandom_range(0, 24));
            run_seq(hw, 1'b0, (r % 4) == 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule